// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Errors

This block recovers asynchronous serial characters from a single data line. A clock enable pulses at sixteen times the bit rate. The receiver confirms a start bit, then samples every data bit, the optional parity bit and the stop bit near the middle of the bit. Each completed character goes into a sixteen-entry queue together with three error tags: parity, framing and break. The line format is set by static inputs: character length from five to eight bits, whether a parity bit is present, even or odd parity, and forced (stick) parity.

The consumer sees the oldest queued character and its tags at the outputs. It removes that character with a one-cycle pop strobe. Status outputs show whether data is waiting and whether any queued character carries an error. An overrun pulse marks a character that was lost because the queue was full. A trigger output rises when the fill level reaches a programmable threshold. The serial input is assumed to be synchronous to the clock already.

Top module: `osr_rx`

## Requirements
- R1: A start bit is seen when the line is 0 on a tick. The line is checked again eight ticks later. If it is 1 at that check, the receiver returns to idle and stores nothing, so a low pulse shorter than half a bit is ignored.
- R2: Each later bit is sampled sixteen ticks after the previous sample. Data arrives LSB first. The length code `len_i` selects 00=5, 01=6, 10=7 and 11=8 data bits. Data bits above the selected length read as 0 on `rx_data_o`.
- R3: When `par_en_i`=1, one parity bit follows the data. The expected value of that bit is set as follows:
  - With `par_stick_i`=0, the bit makes the count of ones in data plus parity even when `par_even_i`=1, and odd when `par_even_i`=0.
  - With `par_stick_i`=1, the bit is the inverse of `par_even_i`.
  - A mismatch sets the entry's parity tag. When `par_en_i`=0, no parity bit is expected and the tag is 0.
- R4: A 0 sampled at the first stop-bit position sets the entry's framing tag. Only the first stop bit is checked.
- R5: If every sample of a frame is 0 (start, data, parity and stop), the entry is stored with data 0, break tag 1 and framing tag 1. No new start bit is then accepted until the line has been sampled at 1.
- R6: The queue holds 16 entries in arrival order. `rx_data_o`, `perr_o`, `ferr_o` and `brk_o` show the oldest entry. A `pop_i` pulse while data is waiting removes that entry.
- R7: `data_ready_o` is 1 exactly when at least one entry is stored.
- R8: If a character completes while 16 entries are stored and no pop happens in that cycle, `overrun_o` pulses for one cycle. The new character is dropped and the stored entries are unchanged.
- R9: `fifo_err_o` is 1 while any stored entry has a parity, framing or break tag.
- R10: `trig_o` is 1 while the stored count is at or above the threshold selected by `trig_sel_i`: 00=1, 01=4, 10=8, 11=14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial data in, idle high |
| len_i | input | 2 | Character length code |
| par_en_i | input | 1 | A parity bit is present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Forced parity select |
| trig_sel_i | input | 2 | Fill threshold select |
| pop_i | input | 1 | Remove the oldest entry |
| rx_data_o | output | 8 | Oldest entry data |
| perr_o | output | 1 | Oldest entry parity tag |
| ferr_o | output | 1 | Oldest entry framing tag |
| brk_o | output | 1 | Oldest entry break tag |
| data_ready_o | output | 1 | At least one entry stored |
| overrun_o | output | 1 | Character dropped because the queue was full |
| fifo_err_o | output | 1 | Some stored entry carries a tag |
| trig_o | output | 1 | Fill level at or above the threshold |

## Verification
Some properties are checked by assertions on every cycle:
- entering the data phase only after the start bit is confirmed low;
- staying in the post-break hold until the line is high;
- a break entry always carrying zero data and a framing tag;
- the fill count never exceeding the depth, and staying full after a dropped character;
- data-ready clearing after the last pop;
- the error and trigger flags only being raised while data is stored.

Other behaviour only the directed scenarios can show:
- the exact parity rule in each mode;
- the data masking for each length;
- arrival order across a full queue;
- that the character lost on overrun is the newest one;
- the threshold value for each trigger code;
- rejection of a short low glitch.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_entry_t;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic has_tag(input rx_entry_t e);
    return e.perr | e.ferr | e.brk;
  endfunction

endpackage

// File: rtl/osr_rx_sampler.sv
module osr_rx_sampler
  import osr_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic [1:0] len_i,
  input  logic      par_en_i,
  input  logic      par_even_i,
  input  logic      par_stick_i,
  output logic      push_o,
  output rx_entry_t entry_o
);

  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [2:0]     idx_q;
  logic [7:0]     data_q;
  logic           par_q;
  logic           seen_one_q;

  logic mid_cnt, half_cnt, last_bit, exp_par, brk_now;

  assign mid_cnt  = (cnt_q == CW'(OVS - 1));
  assign half_cnt = (cnt_q == CW'(HALF - 1));
  assign last_bit = (idx_q == ({1'b0, len_i} + 3'd4));
  // data_q is cleared at frame start, so unused upper bits are zero
  assign exp_par  = par_stick_i ? ~par_even_i : (par_even_i ? ^data_q : ~(^data_q));
  assign brk_now  = ~seen_one_q & ~rxd_i;

  assign push_o        = tick_i && (state_q == ST_STOP) && mid_cnt;
  assign entry_o.data  = data_q;
  assign entry_o.perr  = par_en_i & (par_q != exp_par);
  assign entry_o.ferr  = ~rxd_i;
  assign entry_o.brk   = brk_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      data_q     <= '0;
      par_q      <= 1'b0;
      seen_one_q <= 1'b0;
    end else if (tick_i) begin
      case (state_q)
        ST_IDLE: begin
          if (!rxd_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        ST_START: begin
          if (half_cnt) begin
            cnt_q <= '0;
            if (rxd_i) begin
              state_q <= ST_IDLE;
            end else begin
              state_q    <= ST_DATA;
              idx_q      <= '0;
              data_q     <= '0;
              par_q      <= 1'b0;
              seen_one_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (mid_cnt) begin
            cnt_q         <= '0;
            data_q[idx_q] <= rxd_i;
            seen_one_q    <= seen_one_q | rxd_i;
            if (last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else          idx_q   <= idx_q + 3'd1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (mid_cnt) begin
            cnt_q      <= '0;
            par_q      <= rxd_i;
            seen_one_q <= seen_one_q | rxd_i;
            state_q    <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (mid_cnt) begin
            cnt_q   <= '0;
            state_q <= brk_now ? ST_HOLD : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (rxd_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_start_confirmed_low_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(rxd_i));

  assert_hold_until_high_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_HOLD && state_q != ST_HOLD) |-> $past(rxd_i));

  assert_break_zero_data_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && entry_o.brk) |-> (entry_o.data == 8'h00 && entry_o.ferr));

endmodule

// File: rtl/osr_rx_fifo.sv
module osr_rx_fifo
  import osr_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_entry_t     entry_i,
  input  logic          pop_i,
  output rx_entry_t     head_o,
  output logic [CW-1:0] count_o,
  output logic          data_ready_o,
  output logic          ovr_o,
  output logic          err_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_entry_t      mem_q [DEPTH];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  count_q, err_cnt_q;
  logic           full, empty, do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & (~full | do_pop);

  assign head_o       = mem_q[rd_ptr_q];
  assign count_o      = count_q;
  assign data_ready_o = ~empty;
  assign ovr_o        = push_i & full & ~do_pop;
  assign err_o        = (err_cnt_q != '0);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      err_cnt_q <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q   <= count_q + CW'(do_push) - CW'(do_pop);
      err_cnt_q <= err_cnt_q + CW'(do_push & has_tag(entry_i))
                             - CW'(do_pop & has_tag(head_o));
    end
  end

  assert_count_bound_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  assert_drop_keeps_full_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> (count_q == CW'(DEPTH)));

  assert_empty_after_last_pop_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_q == CW'(1) && !push_i) |=> !data_ready_o);

  assert_err_needs_entry_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> data_ready_o);

endmodule

// File: rtl/osr_rx_trig.sv
module osr_rx_trig
  import osr_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] count_i,
  output logic          trig_o
);

  logic [CW-1:0] thr;

  always_comb thr = CW'(trig_level(sel_i));

  assign trig_o = (count_i >= thr);

endmodule

// File: rtl/osr_rx.sv
module osr_rx
  import osr_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       rxd_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic [1:0] trig_sel_i,
  input  logic       pop_i,
  output logic [7:0] rx_data_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       brk_o,
  output logic       data_ready_o,
  output logic       overrun_o,
  output logic       fifo_err_o,
  output logic       trig_o
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          push;
  rx_entry_t     entry, head;
  logic [CW-1:0] count;

  osr_rx_sampler #(.OVS(OVS)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .rxd_i      (rxd_i),
    .len_i      (len_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .par_stick_i(par_stick_i),
    .push_o     (push),
    .entry_o    (entry)
  );

  osr_rx_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .entry_i     (entry),
    .pop_i       (pop_i),
    .head_o      (head),
    .count_o     (count),
    .data_ready_o(data_ready_o),
    .ovr_o       (overrun_o),
    .err_o       (fifo_err_o)
  );

  osr_rx_trig #(.DEPTH(DEPTH), .CW(CW)) u_trig (
    .sel_i  (trig_sel_i),
    .count_i(count),
    .trig_o (trig_o)
  );

  assign rx_data_o = head.data;
  assign perr_o    = head.perr;
  assign ferr_o    = head.ferr;
  assign brk_o     = head.brk;

  assert_trig_needs_data_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> data_ready_o);

endmodule

// File: tb/osr_rx_test.sv
`timescale 1ns/1ps
module osr_rx_test;

  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len = 2'b11;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       pop = 1'b0;
  logic [7:0] rx_data;
  logic       perr, ferr, brk, data_ready, overrun, fifo_err, trig;

  int vectors = 0, miscompares = 0, ovr_seen = 0;
  logic [1:0] div = 2'd0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  always @(posedge clk) if (overrun) ovr_seen++;

  osr_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .len_i(len), .par_en_i(par_en), .par_even_i(par_even), .par_stick_i(par_stick),
    .trig_sel_i(trig_sel), .pop_i(pop),
    .rx_data_o(rx_data), .perr_o(perr), .ferr_o(ferr), .brk_o(brk),
    .data_ready_o(data_ready), .overrun_o(overrun), .fifo_err_o(fifo_err), .trig_o(trig)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int nb);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (par_stick) return ~par_even;
    return par_even ? x : ~x;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_val);
    int nb = int'(len) + 5;
    @(negedge clk);
    rxd = 1'b0; wait_bits(1);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_bits(1); end
    if (par_en) begin rxd = par_bit(d, nb) ^ bad_par; wait_bits(1); end
    rxd = stop_val; wait_bits(1);
    rxd = 1'b1; wait_bits(1);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic test_reset();
    check("R7", "data_ready after reset", data_ready, 0);
    check("R9", "fifo_err after reset", fifo_err, 0);
    check("R10", "trig after reset", trig, 0);
    check("R8", "overrun after reset", overrun, 0);
  endtask

  task automatic test_basic();
    len = 2'b11; par_en = 0;
    send_frame(8'hA7, 0, 1);
    check("R7", "data_ready one entry", data_ready, 1);
    check("R2", "8-bit data", rx_data, 8'hA7);
    check("R6", "clean tags", {perr, ferr, brk}, 0);
    send_frame(8'h3C, 0, 1);
    check("R6", "head still first", rx_data, 8'hA7);
    do_pop();
    check("R6", "second after pop", rx_data, 8'h3C);
    do_pop();
    check("R7", "empty after pops", data_ready, 0);
  endtask

  task automatic test_lengths();
    par_en = 0;
    len = 2'b00; send_frame(8'hF5, 0, 1);
    check("R2", "5-bit masked", rx_data, 8'h15); do_pop();
    len = 2'b01; send_frame(8'hEA, 0, 1);
    check("R2", "6-bit masked", rx_data, 8'h2A); do_pop();
    len = 2'b10; send_frame(8'hEB, 0, 1);
    check("R2", "7-bit masked", rx_data, 8'h6B); do_pop();
    len = 2'b11;
  endtask

  task automatic test_parity();
    len = 2'b11; par_en = 1;
    par_stick = 0; par_even = 1;
    send_frame(8'h35, 0, 1); check("R3", "even ok", {perr, rx_data}, {1'b0, 8'h35}); do_pop();
    send_frame(8'h35, 1, 1); check("R3", "even bad", perr, 1); do_pop();
    par_even = 0;
    send_frame(8'h81, 0, 1); check("R3", "odd ok", perr, 0); do_pop();
    send_frame(8'h81, 1, 1); check("R3", "odd bad", perr, 1); do_pop();
    par_stick = 1; par_even = 0;
    send_frame(8'h12, 0, 1); check("R3", "stick one ok", perr, 0); do_pop();
    par_even = 1;
    send_frame(8'h12, 1, 1); check("R3", "stick zero bad", perr, 1); do_pop();
    par_en = 0;
    send_frame(8'h12, 0, 1); check("R3", "parity off", {perr, rx_data}, {1'b0, 8'h12}); do_pop();
    par_stick = 0; par_even = 0;
  endtask

  task automatic test_framing();
    len = 2'b11; par_en = 0;
    send_frame(8'h11, 0, 1);
    check("R9", "no err clean", fifo_err, 0);
    send_frame(8'hA5, 0, 0);
    check("R9", "err behind head", fifo_err, 1);
    check("R4", "head clean", ferr, 0);
    do_pop();
    check("R4", "framing tag", {ferr, brk, rx_data}, {1'b1, 1'b0, 8'hA5});
    check("R9", "err still held", fifo_err, 1);
    do_pop();
    check("R9", "err cleared", fifo_err, 0);
    check("R4", "no extra entry", data_ready, 0);
  endtask

  task automatic test_break();
    len = 2'b11; par_en = 0;
    @(negedge clk) rxd = 1'b0;
    wait_bits(13);
    rxd = 1'b1; wait_bits(2);
    check("R5", "break entry", {brk, ferr, rx_data}, {1'b1, 1'b1, 8'h00});
    check("R9", "break sets err", fifo_err, 1);
    send_frame(8'h5A, 0, 1);
    do_pop();
    check("R5", "next frame after high", {data_ready, brk, rx_data}, {1'b1, 1'b0, 8'h5A});
    do_pop();
    check("R5", "single break entry", data_ready, 0);
  endtask

  task automatic test_glitch();
    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    wait_bits(12);
    check("R1", "glitch rejected", data_ready, 0);
    send_frame(8'hC3, 0, 1);
    check("R1", "recovers after glitch", rx_data, 8'hC3);
    do_pop();
  endtask

  task automatic test_fill();
    int base;
    len = 2'b11; par_en = 0;
    base = ovr_seen;
    for (int k = 1; k <= 16; k++) begin
      send_frame(8'h30 + 8'(k), 0, 1);
      for (int s = 0; s < 4; s++) begin
        int thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
        @(negedge clk) trig_sel = 2'(s);
        @(negedge clk);
        check("R10", $sformatf("trig count %0d sel %0d", k, s), trig, (k >= thr));
      end
    end
    check("R8", "no overrun while filling", ovr_seen - base, 0);
    send_frame(8'hEE, 0, 1);
    check("R8", "one overrun pulse", ovr_seen - base, 1);
    for (int k = 1; k <= 16; k++) begin
      check("R6", $sformatf("order entry %0d", k), rx_data, 8'h30 + 8'(k));
      do_pop();
    end
    check("R8", "dropped byte absent", data_ready, 0);
    trig_sel = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_basic();
    test_lengths();
    test_parity();
    test_framing();
    test_break();
    test_glitch();
    test_fill();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule